// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for a synchronous burst memory. On a clock edge where an address strobe is accepted, it captures the external address. While no strobe is accepted, it either steps the low-order burst bits, when the advance input is high, or holds them, when advance is low. The upper address bits stay fixed from one load to the next. The step order is linear or interleaved, chosen by an order-select input that is captured together with the address.

There are two strobes. The processor-side strobe counts only while the chip enable is high. The controller-side strobe counts whatever the enable is. An accepted strobe always wins over advance. Bursting is optional: a strobe on every clock loads a fresh address each cycle at full rate. The output is driven combinationally from registered state, so it is valid right after the edge that updated that state.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the generator clears to address 0 with interleaved order, so `addr_out` reads 0 after that edge.
- R2: When `strb_ctl` is high at an edge, `addr_out` equals the `addr_in` sampled there after that edge, whatever the value of `cen`.
- R3: When `strb_cpu` is high at an edge, it loads `addr_in` only if `cen` is also high. With `cen` low it is ignored, and the hold or step rule applies instead.
- R4: An accepted strobe takes precedence over `adv`. With both present, the burst restarts at `addr_in` and does not step.
- R5: With no accepted strobe and `adv` high, the burst position advances by one. With no accepted strobe and `adv` low, `addr_out` is unchanged.
- R6: In linear order (`order_lin`=1 at load), the two low bits after n advances equal (start + n) mod 4, for example 1,2,3,0.
- R7: In interleaved order (`order_lin`=0 at load), the two low bits after n advances equal start XOR (n mod 4), for example 1,0,3,2.
- R8: `order_lin` is sampled only on a load edge. Changing it during a burst does not alter the sequence.
- R9: The bits above the two low bits change only on a load. After four advances the sequence wraps within the same aligned group of four, with no carry upward.
- R10: A load on every consecutive edge presents each new address on the cycle after its edge, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cen | input | 1 | Chip enable; qualifies the processor-side strobe |
| strb_cpu | input | 1 | Processor-side address strobe |
| strb_ctl | input | 1 | Controller-side address strobe |
| adv | input | 1 | Burst advance |
| order_lin | input | 1 | 1 selects linear order, 0 selects interleaved |
| addr_in | input | ADDR_W | External starting address |
| addr_out | output | ADDR_W | Current burst address to the array |

## Verification
The bench sweeps both orders from every starting low value and several upper-bit patterns, including all ones, and advances past four steps. A design that carried into the upper bits or picked the wrong order would show a wrong address at the wrap point. Processor strobes with the enable low are mixed with advance high and low, so a design that accepted the ungated strobe reloads where it should hold or step. Strobe-plus-advance collisions, order flips in mid-burst and a run of back-to-back loads catch a design that steps when it should restart, follows the live order pin, or delays a load by a cycle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic {
        ORD_INTLV = 1'b0,
        ORD_LIN   = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } action_e;

    function automatic action_e pick_action(input logic cen,
                                            input logic cpu,
                                            input logic ctl,
                                            input logic adv);
        if (ctl || (cpu && cen)) return ACT_LOAD;
        if (adv)                 return ACT_STEP;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/bag_cmd_dec.sv
module bag_cmd_dec
    import burst_addr_pkg::*;
(
    input  logic    cen,
    input  logic    strb_cpu,
    input  logic    strb_ctl,
    input  logic    adv,
    output action_e act
);
    always_comb act = pick_action(cen, strb_cpu, strb_ctl, adv);
endmodule

// File: rtl/bag_seq_reg.sv
module bag_seq_reg
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  action_e           act,
    input  logic              order_in,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_q,
    output logic [CNT_W-1:0]  cnt_q,
    output order_e            order_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            cnt_q   <= '0;
            order_q <= ORD_INTLV;
        end else begin
            case (act)
                ACT_LOAD: begin
                    base_q  <= addr_in;
                    cnt_q   <= '0;
                    order_q <= order_in ? ORD_LIN : ORD_INTLV;
                end
                ACT_STEP: cnt_q <= cnt_q + 1'b1;
                default:  ;
            endcase
        end
    end

    // R8
    order_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (act != ACT_LOAD) |=> $stable(order_q));

    // R9
    base_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (act != ACT_LOAD) |=> $stable(base_q));
endmodule

// File: rtl/bag_order.sv
module bag_order
    import burst_addr_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start,
    input  logic [CNT_W-1:0] cnt,
    input  order_e           order,
    output logic [CNT_W-1:0] low
);
    always_comb begin
        if (order == ORD_LIN) low = start + cnt;
        else                  low = start ^ cnt;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cen,
    input  logic              strb_cpu,
    input  logic              strb_ctl,
    input  logic              adv,
    input  logic              order_lin,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - CNT_W;

    action_e             act;
    logic [ADDR_W-1:0]   base_q;
    logic [CNT_W-1:0]    cnt_q;
    order_e              order_q;
    logic [CNT_W-1:0]    low;

    bag_cmd_dec u_dec (
        .cen      (cen),
        .strb_cpu (strb_cpu),
        .strb_ctl (strb_ctl),
        .adv      (adv),
        .act      (act)
    );

    bag_seq_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .order_in (order_lin),
        .addr_in  (addr_in),
        .base_q   (base_q),
        .cnt_q    (cnt_q),
        .order_q  (order_q)
    );

    bag_order #(.CNT_W(CNT_W)) u_ord (
        .start (base_q[CNT_W-1:0]),
        .cnt   (cnt_q),
        .order (order_q),
        .low   (low)
    );

    assign addr_out = {base_q[ADDR_W-1:CNT_W], low};

    // R2
    ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
        strb_ctl |=> (addr_out == $past(addr_in)));

    // R3
    cpu_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (strb_cpu && !cen && !strb_ctl && !adv) |=> $stable(addr_out));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!strb_ctl && !(strb_cpu && cen) && !adv) |=> $stable(addr_out));

    // R9
    upper_chk: assert property (@(posedge clk) disable iff (rst)
        (!strb_ctl && !(strb_cpu && cen))
        |=> (addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])));

    // R6
    lin_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!strb_ctl && !(strb_cpu && cen) && adv && order_q == ORD_LIN)
        |=> (addr_out[CNT_W-1:0] == CNT_W'($past(addr_out[CNT_W-1:0]) + 1'b1)));

    initial begin
        hi_width_chk: assert (HI_W > 0);
    end
endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst, cen, strb_cpu, strb_ctl, adv, order_lin;
    logic [AW-1:0] addr_in, addr_out;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench-side expectation state
    logic [AW-1:0] m_base;
    int            m_n;
    bit            m_lin;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .CNT_W(2)) u0 (
        .clk(clk), .rst(rst), .cen(cen), .strb_cpu(strb_cpu),
        .strb_ctl(strb_ctl), .adv(adv), .order_lin(order_lin),
        .addr_in(addr_in), .addr_out(addr_out)
    );

    function automatic logic [AW-1:0] expect_addr();
        int st = int'(m_base[1:0]);
        int lo = m_lin ? ((st + m_n) % 4) : (st ^ (m_n % 4));
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic cycle(input bit c, input bit pc, input bit pt, input bit a,
                         input bit lin, input logic [AW-1:0] ad, input string tag);
        @(negedge clk);
        cen = c; strb_cpu = pc; strb_ctl = pt; adv = a; order_lin = lin; addr_in = ad;
        if (pt || (pc && c)) begin
            m_base = ad; m_n = 0; m_lin = lin;
        end else if (a) begin
            m_n = m_n + 1;
        end
        @(posedge clk);
        #1;
        n_chk++;
        if (addr_out !== expect_addr()) begin
            n_fail++;
            $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, expect_addr());
        end
    endtask

    initial begin
        rst = 1; cen = 0; strb_cpu = 0; strb_ctl = 0; adv = 0; order_lin = 1; addr_in = '1;
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (addr_out !== '0) begin
            n_fail++;
            $display("FAIL R1: addr_out=%h expected=%h", addr_out, {AW{1'b0}});
        end
        m_base = '0; m_n = 0; m_lin = 0;
        @(negedge clk); rst = 0;
        // R1: reset order is interleaved; step from 0 gives 1
        cycle(0, 0, 0, 1, 1, '0, "R1");

        // R2 R6 R7 R9: exhaustive sweep of order, start low bits and upper patterns
        for (int mode = 0; mode < 2; mode++)
            for (int st = 0; st < 4; st++)
                for (int up = 0; up < 3; up++) begin
                    logic [AW-3:0] hi = (up == 0) ? '0 : (up == 1) ? '1 : (AW-2)'(9'h15a);
                    cycle(st[0], 0, 1, 0, mode[0], {hi, 2'(st)}, "R2");
                    for (int k = 0; k < 7; k++)
                        cycle(1, 0, 0, 1, ~mode[0], '0, mode ? "R6" : "R7");
                    cycle(1, 0, 0, 0, mode[0], '1, "R5");
                    cycle(1, 0, 0, 1, mode[0], '1, "R9");
                end

        // R3: ungated processor strobe ignored, hold and step rules apply
        cycle(1, 1, 0, 0, 1, 10'h2c1, "R3");
        cycle(0, 1, 0, 0, 0, 10'h0f3, "R3");
        cycle(0, 1, 0, 1, 0, 10'h0f3, "R3");
        cycle(0, 1, 0, 1, 1, 10'h155, "R3");

        // R4: strobes beat advance
        cycle(1, 1, 0, 1, 0, 10'h3a6, "R4");
        cycle(0, 0, 1, 1, 1, 10'h1b3, "R4");
        cycle(1, 1, 1, 1, 0, 10'h27e, "R4");

        // R8: order pin flips mid-burst
        cycle(1, 0, 1, 0, 0, 10'h0c1, "R8");
        for (int k = 0; k < 5; k++)
            cycle(1, 0, 0, 1, k[0], '0, "R8");
        cycle(1, 0, 1, 0, 1, 10'h0c2, "R8");
        for (int k = 0; k < 5; k++)
            cycle(1, 0, 0, 1, ~k[0], '0, "R8");

        // R10: back-to-back loads, alternating strobes
        for (int k = 0; k < 10; k++)
            cycle(1, k[0], ~k[0], k[1], k[2], AW'(k * 97 + 13), "R10");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule